// File: doc/BRIEF.md
# Unsigned Integer to Float Converter

This block turns an unsigned integer operand into a packed IEEE-754 binary floating-point value. Two parameters set its shape: `SRC_W` picks a 32-bit or 64-bit operand, and `DBL` picks a single-precision (0) or double-precision (1) result. When the operand holds more significant bits than the result fraction can keep, the block rounds the result using a 2-bit rounding-mode input. It then reports the lost precision in one of two ways: as a one-cycle trap pulse, or in a sticky status flag.

To start a conversion, raise `in_valid` for one cycle with the operand, the rounding mode and the trap enable. The registered result appears on the next cycle with `out_valid` high. The result holds its value until the next conversion. The sticky flag stays set until software-side control pulses `clr_flag`.

Top module: `uint_to_float`

## Requirements
- R1: An all-zero operand gives a result with every bit zero. It never raises `inexact_trap` and never sets `inexact_flag`.
- R2: The sign bit, which is the result MSB, is always 0.
- R3: For a nonzero operand with its highest set bit at index k, the biased exponent field is bias+k. The bias is 127 for single precision and 1023 for double. The fraction field holds the operand bits below k, left-justified, and the leading one is implied.
- R4: `out_valid` is high exactly one cycle after `in_valid`, and the result for that operand appears in that same cycle. When no conversion completes, `out_result` keeps its value.
- R5: A conversion is inexact when any operand bit below the bits the fraction can hold is 1.
- R6: Mode 2'b00 rounds to nearest with ties to even. The result increments when the first discarded bit is 1 and either a lower discarded bit is 1 or the result LSB is 1.
- R7: Mode 2'b01 truncates, rounding toward zero.
- R8: Mode 2'b10 adds one unit in the last place to every inexact result. A carry out of the fraction ripples into the exponent.
- R9: Mode 2'b11 truncates, because the value is never negative.
- R10: An inexact conversion with `trap_en`=1 still delivers the rounded result. It pulses `inexact_trap` for that one output cycle and leaves `inexact_flag` unchanged.
- R11: An inexact conversion with `trap_en`=0 sets `inexact_flag`. The flag then holds until `clr_flag` is sampled high. If a clear and a new setting event arrive in the same cycle, the flag ends up set.
- R12: With a 32-bit operand and a double-precision result, every conversion is exact: no rounding and no inexact report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Starts a conversion |
| in_data | input | SRC_W | Unsigned operand |
| rnd_mode | input | 2 | Rounding mode code |
| trap_en | input | 1 | Report inexact as a trap pulse instead of the flag |
| clr_flag | input | 1 | Clears the sticky inexact flag |
| out_valid | output | 1 | Result valid |
| out_result | output | 1+EXP_W+FRAC_W | Packed floating-point result |
| inexact_trap | output | 1 | Inexact exception pulse |
| inexact_flag | output | 1 | Sticky inexact status |

## Verification
Two updates can hit the sticky flag in the same cycle: a flag clear and a new untrapped inexact conversion. The bench pulses `clr_flag` in the same cycle as an inexact operand with the trap off, and expects the flag to read 1 afterwards. A clear with no inexact event must leave the flag at 0. Rounding can also land together with exponent adjustment. An all-ones fraction that rounds up must carry cleanly into the exponent field, and the bench judges this against exact hand-computed bit patterns.

// File: rtl/uint_to_float.sv
module uint_to_float #(
  parameter int SRC_W = 64,
  parameter bit DBL   = 1'b0
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         in_valid,
  input  logic [SRC_W-1:0]                             in_data,
  input  logic [1:0]                                   rnd_mode,
  input  logic                                         trap_en,
  input  logic                                         clr_flag,
  output logic                                         out_valid,
  output logic [(DBL ? 64 : 32)-1:0]                   out_result,
  output logic                                         inexact_trap,
  output logic                                         inexact_flag
);
  localparam int EXP_W  = DBL ? 11 : 8;
  localparam int FRAC_W = DBL ? 52 : 23;
  localparam int RES_W  = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int IDX_W  = $clog2(SRC_W);
  localparam int EW     = SRC_W + FRAC_W;
  localparam bit EXACT  = (SRC_W - 1) <= FRAC_W;

  logic [IDX_W-1:0] top;
  always_comb begin
    top = '0;
    for (int i = 0; i < SRC_W; i++)
      if (in_data[i]) top = i[IDX_W-1:0];
  end

  logic             is_zero;
  logic [IDX_W-1:0] lsh;
  logic [SRC_W-1:0] norm;
  logic [EW-1:0]    ext;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W-1:0] expo;
  logic             grd, stk, inexact, rnd_up;
  logic [RES_W-1:0] res_n;

  assign is_zero = (in_data == '0);
  assign lsh     = IDX_W'(SRC_W - 1) - top;
  assign norm    = in_data << lsh;
  assign ext     = {norm[SRC_W-2:0], {(FRAC_W+1){1'b0}}};
  assign frac    = ext[EW-1 -: FRAC_W];
  assign grd     = ext[EW-1-FRAC_W];
  assign stk     = |ext[EW-2-FRAC_W:0];
  assign inexact = !is_zero && (grd || stk);
  assign expo    = EXP_W'(BIAS) + EXP_W'(top);

  always_comb begin
    case (rnd_mode)
      2'b00:   rnd_up = grd && (stk || frac[0]);
      2'b10:   rnd_up = inexact;
      default: rnd_up = 1'b0;
    endcase
  end

  assign res_n = is_zero ? '0 : ({1'b0, expo, frac} + RES_W'(rnd_up));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      inexact_trap <= 1'b0;
      inexact_flag <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      inexact_trap <= in_valid && inexact && trap_en;
      if (in_valid) out_result <= res_n;
      if (in_valid && inexact && !trap_en) inexact_flag <= 1'b1;
      else if (clr_flag)                   inexact_flag <= 1'b0;
    end
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_result[RES_W-1]);
  p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '0) |=> (out_result == '0 && !inexact_trap));
  p_trap_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !trap_en) |=> !inexact_trap);
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inexact_flag && !clr_flag) |=> inexact_flag);
  p_exact_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && EXACT) |=> (!inexact_trap && $stable(inexact_flag)));
endmodule

// File: tb/test_uint_to_float.sv
module test_uint_to_float;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 1'b0, trap_en = 1'b0, clr_flag = 1'b0;
  logic [63:0] in_data = '0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        out_valid, inexact_trap, inexact_flag;
  logic [31:0] out_result;

  logic        b_valid = 1'b0;
  logic [31:0] b_data = '0;
  logic        b_ovalid, b_trap, b_flag;
  logic [63:0] b_result;

  int checks = 0, fails = 0;

  uint_to_float #(.SRC_W(64), .DBL(1'b0)) i_uint_to_float (
    .clk, .rst_n, .in_valid, .in_data, .rnd_mode, .trap_en, .clr_flag,
    .out_valid, .out_result, .inexact_trap, .inexact_flag);

  uint_to_float #(.SRC_W(32), .DBL(1'b1)) i_uint_to_float_d (
    .clk, .rst_n, .in_valid(b_valid), .in_data(b_data), .rnd_mode,
    .trap_en(1'b0), .clr_flag(1'b0), .out_valid(b_ovalid),
    .out_result(b_result), .inexact_trap(b_trap), .inexact_flag(b_flag));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic conv(logic [63:0] d, logic [1:0] m, logic t, logic c);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; rnd_mode = m; trap_en = t; clr_flag = c;
    @(negedge clk);
    in_valid = 1'b0; clr_flag = 1'b0;
  endtask

  task automatic conv_chk(string req, logic [63:0] d, logic [1:0] m,
                          logic [31:0] exp, logic exp_inx);
    conv(d, m, 1'b1, 1'b0);
    chk(req, {63'd0, out_valid}, 64'd1);
    chk(req, {32'd0, out_result}, {32'd0, exp});
    chk(req, {63'd0, inexact_trap}, {63'd0, exp_inx});
  endtask

  task automatic t_zero_r1;
    conv(64'd0, 2'b10, 1'b0, 1'b0);
    chk("R1", {32'd0, out_result}, 64'd0);
    chk("R1", {62'd0, inexact_trap, inexact_flag}, 64'd0);
  endtask

  task automatic t_exp_r3;
    conv_chk("R3", 64'd1, 2'b00, 32'h3F80_0000, 1'b0);
    conv_chk("R3", 64'h1_0000_0000, 2'b00, 32'h4F80_0000, 1'b0);
    conv_chk("R3 R2", 64'h8000_0000_0000_0000, 2'b00, 32'h5F00_0000, 1'b0);
    conv_chk("R3 R5", 64'h00FF_FFFF, 2'b10, 32'h4B7F_FFFF, 1'b0);
  endtask

  task automatic t_hold_r4;
    @(negedge clk);
    chk("R4", {63'd0, out_valid}, 64'd0);
    chk("R4", {32'd0, out_result}, 64'h4B7F_FFFF);
  endtask

  task automatic t_modes;
    conv_chk("R6 tie even", 64'h0100_0001, 2'b00, 32'h4B80_0000, 1'b1);
    conv_chk("R6 tie odd", 64'h0100_0003, 2'b00, 32'h4B80_0002, 1'b1);
    conv_chk("R6 below half", 64'h0200_0001, 2'b00, 32'h4C00_0000, 1'b1);
    conv_chk("R6 carry", 64'h01FF_FFFF, 2'b00, 32'h4C00_0000, 1'b1);
    conv_chk("R7", 64'h0100_0003, 2'b01, 32'h4B80_0001, 1'b1);
    conv_chk("R8", 64'h0200_0001, 2'b10, 32'h4C00_0001, 1'b1);
    conv_chk("R8 carry", 64'h01FF_FFFF, 2'b10, 32'h4C00_0000, 1'b1);
    conv_chk("R9", 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 32'h5F7F_FFFF, 1'b1);
    conv_chk("R6 max", 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 32'h5F80_0000, 1'b1);
  endtask

  task automatic t_trap_r10;
    conv(64'd0, 2'b00, 1'b0, 1'b1);
    chk("R11 clear", {63'd0, inexact_flag}, 64'd0);
    conv(64'h0200_0001, 2'b10, 1'b1, 1'b0);
    chk("R10", {32'd0, out_result}, 64'h4C00_0001);
    chk("R10", {62'd0, inexact_trap, inexact_flag}, 64'b10);
    @(negedge clk);
    chk("R10 pulse", {63'd0, inexact_trap}, 64'd0);
  endtask

  task automatic t_flag_r11;
    conv(64'h0100_0001, 2'b00, 1'b0, 1'b0);
    chk("R11 set", {62'd0, inexact_trap, inexact_flag}, 64'b01);
    conv(64'd5, 2'b00, 1'b0, 1'b0);
    chk("R11 hold", {63'd0, inexact_flag}, 64'd1);
    conv(64'd5, 2'b00, 1'b0, 1'b1);
    chk("R11 clear", {63'd0, inexact_flag}, 64'd0);
    conv(64'h0100_0001, 2'b00, 1'b0, 1'b1);
    chk("R11 set wins", {63'd0, inexact_flag}, 64'd1);
  endtask

  task automatic t_exact_r12;
    @(negedge clk);
    b_valid = 1'b1; b_data = 32'hFFFF_FFFF; rnd_mode = 2'b10;
    @(negedge clk);
    b_valid = 1'b0;
    chk("R12", b_result, 64'h41EF_FFFF_FFE0_0000);
    chk("R12", {62'd0, b_trap, b_flag}, 64'd0);
    @(negedge clk);
    b_valid = 1'b1; b_data = 32'd1;
    @(negedge clk);
    b_valid = 1'b0;
    chk("R12 R3", b_result, 64'h3FF0_0000_0000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R4 reset", {62'd0, out_valid, inexact_flag}, 64'd0);
    chk("R4 reset", {32'd0, out_result}, 64'd0);
    t_zero_r1();
    t_exp_r3();
    t_hold_r4();
    t_modes();
    t_trap_r10();
    t_flag_r11();
    t_exact_r12();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule